// File: doc/BRIEF.md
# Prioritized Address Window Chip-Select Decoder

This block sits beside an external bus sequencer and decides which chip-select line belongs to each bus cycle. Four address windows are held in registers. Each has an enable bit, a base block number, a power-of-two size and its own READY settings. A fifth, default configuration covers every address that falls in no enabled window. When the sequencer raises ALE, the block latches the decision. It drives exactly one active-low chip-select, reports the winning configuration index, and supplies that configuration's READY enable and READY polarity.

Overlapping windows are resolved in two steps. Window 4 beats window 3, and window 2 beats window 1. If both groups have a hit, the winner from the upper group {4,3} takes the cycle. A control bit sets when the chip-selects move. In the default timing they change half a clock after the edge that samples ALE high, by way of a falling-edge register. In early timing they change on that edge itself, together with the address.

All settings are loaded through a single write port. The port selects one slot at a time: the default configuration, one of the four windows, or the control bit.

Top module: `csd_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, all five chip-selects are high, `cfg_idx` is 0, every window is disabled, READY enable is 0, early timing is off, and a cycle at any address selects the default configuration.
- R2: Window k (1..4) matches when it is enabled and the bits of `addr_blk` at positions `sz` and above equal the same bits of its base. The window then spans 4 KB << `sz`, and base bits below `sz` are ignored.
- R3: Within a group, the higher window wins: window 4 over window 3, and window 2 over window 1.
- R4: When one window from {4,3} and one from {2,1} both match, the window from {4,3} is selected.
- R5: An address that matches no enabled window selects index 0 and drives `cs_n[0]` low.
- R6: During an active cycle exactly one line `cs_n[i]` is low, with i equal to `cfg_idx` (bit 0 = default, bit k = window k). A `cyc_end` pulse returns all lines high, with the same timing offset as the assertion.
- R7: With early timing on (control slot bit 0 = 1), the chip-select changes on the rising clock edge at which ALE is first sampled high. `cfg_idx`, `rdy_en` and `rdy_pol` update on that same edge.
- R8: With early timing off, chip-select changes (assertion and release) appear on the falling clock edge that follows, half a clock later.
- R9: The decision is captured at the ALE rise. Changes of `addr_blk` later in the cycle do not change `cs_n` or `cfg_idx`.
- R10: `rdy_en` and `rdy_pol` give the READY settings of the selected configuration (default or window).
- R11: A window whose enable bit is 0 never matches, even if its base and size cover the address.
- R12: A write with `wr_sel` 0 loads the default READY bits. A write with `wr_sel` 1..4 loads that window. A write with `wr_sel` 5 loads the control bit (data bit 0 = early timing). The data fields are: bit 0 enable, bit 1 READY enable, bit 2 READY polarity, bits 6:3 size exponent, bits 18:7 base block number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; decision registers on the rising edge, delayed chip-select on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write slot: 0 default, 1..4 window, 5 control |
| wr_data | input | 19 | Write data in the field layout of R12 |
| ale | input | 1 | Address latch enable from the bus sequencer; its rise starts a cycle |
| cyc_end | input | 1 | One-clock pulse that ends the current cycle |
| addr_blk | input | 12 | Bus address bits 23:12 (4 KB block number) |
| cs_n | output | 5 | Active-low chip-selects; bit 0 default, bit k window k |
| cfg_idx | output | 3 | Selected configuration, 0 default, 1..4 window |
| rdy_en | output | 1 | READY enable of the selected configuration |
| rdy_pol | output | 1 | READY active level of the selected configuration |

## Verification
The properties assume three things. ALE stays low through reset. The timing bit and the window registers are rewritten only while no cycle is active. A new ALE rise does not arrive in the same clock as `cyc_end`. The stimulus keeps to these rules: every programming write happens between cycles, and each cycle runs the fixed sequence of ALE rise, ALE fall, then an end pulse one clock later. The delayed timing is observed by sampling after the falling edge, and the early timing by sampling just after the rising edge.

// File: rtl/csd_pkg.sv
// Shared constants and types for the window chip-select decoder.
// Assumes exactly four windows arranged as two override groups.
package csd_pkg;
    localparam int NUM_WIN   = 4;
    localparam int NUM_CS    = NUM_WIN + 1;
    localparam int BLK_SHIFT = 12;
    localparam int SZ_W      = 4;
    localparam int IDX_W     = 3;
    localparam int FLD_BASE  = 7;
    localparam logic [IDX_W-1:0] SEL_DEF  = 3'd0;
    localparam logic [IDX_W-1:0] SEL_CTRL = 3'd5;

    typedef struct packed {
        logic pol;
        logic en;
    } rdy_cfg_t;
endpackage

// File: rtl/csd_win_match.sv
// Single-window comparator: flags a hit when the block number agrees with
// the base on every bit from the size exponent upward.
// Assumes the size exponent counts 4 KB granules as a power of two.
module csd_win_match #(
    parameter int BLK_W = 12,
    parameter int SZ_W  = 4
) (
    input  logic             en,
    input  logic [BLK_W-1:0] base,
    input  logic [SZ_W-1:0]  sz,
    input  logic [BLK_W-1:0] blk,
    output logic             hit
);
    logic [BLK_W-1:0] diff;

    // Compare only the bits above the window size.
    always_comb begin
        diff = blk ^ base;
        hit  = en && ((diff >> sz) == '0);
    end
endmodule

// File: rtl/csd_prio_resolve.sv
// Resolves window hits into one configuration index: inside each group the
// higher window wins, and the {4,3} group wins over the {2,1} group.
// Assumes hit bit k belongs to window k+1; index 0 means default.
module csd_prio_resolve
    import csd_pkg::*;
(
    input  logic [NUM_WIN-1:0] hit,
    output logic [IDX_W-1:0]   idx
);
    logic             up_any, lo_any;
    logic [IDX_W-1:0] up_idx, lo_idx;

    // Pick a group winner, then let the upper group override the lower one.
    always_comb begin
        up_any = hit[3] | hit[2];
        lo_any = hit[1] | hit[0];
        up_idx = hit[3] ? 3'd4 : 3'd3;
        lo_idx = hit[1] ? 3'd2 : 3'd1;
        if (up_any)      idx = up_idx;
        else if (lo_any) idx = lo_idx;
        else             idx = 3'd0;
    end
endmodule

// File: rtl/csd_cs_timing.sv
// Chip-select timing stage: passes the rising-edge value straight through in
// early mode, or the value re-registered on the falling edge otherwise.
// Assumes the mode bit is changed only while all selects are idle.
module csd_cs_timing #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         early,
    input  logic [W-1:0] cs_rise_n,
    output logic [W-1:0] cs_n
);
    logic [W-1:0] cs_half_n;

    // Delay the selects by half a clock using the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) cs_half_n <= '1;
        else        cs_half_n <= cs_rise_n;
    end

    // Choose the output timing.
    always_comb cs_n = early ? cs_rise_n : cs_half_n;
endmodule

// File: rtl/csd_window_decoder.sv
// Top of the window chip-select decoder: holds the window registers, decodes
// the block number at each ALE rise and drives one chip-select per cycle.
// Assumes cyc_end and a new ALE rise never share a clock.
module csd_window_decoder
    import csd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  wr_en,
    input  logic [IDX_W-1:0]                      wr_sel,
    input  logic [FLD_BASE+ADDR_W-BLK_SHIFT-1:0]  wr_data,
    input  logic                                  ale,
    input  logic                                  cyc_end,
    input  logic [ADDR_W-BLK_SHIFT-1:0]           addr_blk,
    output logic [NUM_CS-1:0]                     cs_n,
    output logic [IDX_W-1:0]                      cfg_idx,
    output logic                                  rdy_en,
    output logic                                  rdy_pol
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;
    localparam int CFG_W = FLD_BASE + BLK_W;

    logic [NUM_WIN-1:0] win_en;
    logic [BLK_W-1:0]   win_base [NUM_WIN];
    logic [SZ_W-1:0]    win_sz   [NUM_WIN];
    rdy_cfg_t           win_rdy  [NUM_WIN];
    rdy_cfg_t           dflt_rdy;
    logic               early_q;

    logic [NUM_WIN-1:0] hit;
    logic [IDX_W-1:0]   res_idx;
    rdy_cfg_t           res_rdy;
    logic               ale_q, ale_rise, act_q;
    logic [NUM_CS-1:0]  cs_rise_n;
    rdy_cfg_t           rdy_q;

    // Load configuration slots from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_en   <= '0;
            dflt_rdy <= '0;
            early_q  <= 1'b0;
            for (int k = 0; k < NUM_WIN; k++) begin
                win_base[k] <= '0;
                win_sz[k]   <= '0;
                win_rdy[k]  <= '0;
            end
        end else if (wr_en) begin
            if (wr_sel == SEL_DEF)  dflt_rdy <= '{pol: wr_data[2], en: wr_data[1]};
            if (wr_sel == SEL_CTRL) early_q  <= wr_data[0];
            for (int k = 0; k < NUM_WIN; k++) begin
                if (wr_sel == IDX_W'(k + 1)) begin
                    win_en[k]   <= wr_data[0];
                    win_rdy[k]  <= '{pol: wr_data[2], en: wr_data[1]};
                    win_sz[k]   <= wr_data[6:3];
                    win_base[k] <= wr_data[CFG_W-1:FLD_BASE];
                end
            end
        end
    end

    // One comparator per window.
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        csd_win_match #(.BLK_W(BLK_W), .SZ_W(SZ_W)) u_match (
            .en   (win_en[g]),
            .base (win_base[g]),
            .sz   (win_sz[g]),
            .blk  (addr_blk),
            .hit  (hit[g])
        );
    end

    csd_prio_resolve u_prio (
        .hit (hit),
        .idx (res_idx)
    );

    // Fetch the READY settings of the winning configuration.
    always_comb begin
        res_rdy = dflt_rdy;
        for (int k = 0; k < NUM_WIN; k++)
            if (res_idx == IDX_W'(k + 1)) res_rdy = win_rdy[k];
    end

    assign ale_rise = ale & ~ale_q;

    // Capture the decision at the ALE rise and release it at cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q     <= 1'b0;
            act_q     <= 1'b0;
            cfg_idx   <= '0;
            rdy_q     <= '0;
            cs_rise_n <= '1;
        end else begin
            ale_q <= ale;
            if (ale_rise) begin
                act_q     <= 1'b1;
                cfg_idx   <= res_idx;
                rdy_q     <= res_rdy;
                cs_rise_n <= ~(NUM_CS'(1) << res_idx);
            end else if (cyc_end) begin
                act_q     <= 1'b0;
                cs_rise_n <= '1;
            end
        end
    end

    csd_cs_timing #(.W(NUM_CS)) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .early     (early_q),
        .cs_rise_n (cs_rise_n),
        .cs_n      (cs_n)
    );

    assign rdy_en  = rdy_q.en;
    assign rdy_pol = rdy_q.pol;
endmodule

// File: rtl/csd_window_decoder_chk.sv
// Property checker for the window decoder, attached to every instance by bind.
// Assumes ALE is low during reset and mode changes happen between cycles.
module csd_window_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       early,
    input logic       act,
    input logic [4:0] cs_n,
    input logic [2:0] cfg_idx
);
    a_r6_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cs_n == 5'h1F && cfg_idx == 3'd0));

    a_r7_early_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (early && ale && !$past(ale)) |=> (!early || cs_n == ~(5'd1 << cfg_idx)));

    a_r9_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
        !(ale && !$past(ale)) |=> $stable(cfg_idx));

    a_r6_active_one: assert property (@(posedge clk) disable iff (!rst_n)
        (early && act) |-> $countones(~cs_n) == 1);

    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (early && !act) |-> cs_n == 5'h1F);
endmodule

bind csd_window_decoder csd_window_decoder_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ale     (ale),
    .early   (early_q),
    .act     (act_q),
    .cs_n    (cs_n),
    .cfg_idx (cfg_idx)
);

// File: tb/csd_window_decoder_bench.sv
`timescale 1ns/100ps
// Self-checking bench: a vector table walked in both timing modes, then
// directed tests for reset, disabled windows and cross-group overrides.
module csd_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [18:0] wr_data = '0;
    logic        ale = 1'b0;
    logic        cyc_end = 1'b0;
    logic [11:0] addr_blk = '0;
    logic [4:0]  cs_n;
    logic [2:0]  cfg_idx;
    logic        rdy_en, rdy_pol;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    bit early_m = 0;
    logic [1:0] exp_rdy [5];   // {pol, en} per configuration index

    always #2.5 clk = ~clk;

    csd_window_decoder u_csd_window_decoder (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .ale(ale), .cyc_end(cyc_end), .addr_blk(addr_blk),
        .cs_n(cs_n), .cfg_idx(cfg_idx), .rdy_en(rdy_en), .rdy_pol(rdy_pol)
    );

    // {full address, expected index}
    localparam logic [26:0] VEC [8] = '{
        {24'h000100, 3'd1},   // R2 inside window 1
        {24'h041234, 3'd2},   // R3 window 2 over window 1
        {24'h0FFFFF, 3'd1},   // R2 last byte of window 1
        {24'h100000, 3'd0},   // R5 just past window 1
        {24'h800010, 3'd3},   // R2 base low bits ignored
        {24'h808ABC, 3'd4},   // R3 window 4 over window 3
        {24'h809000, 3'd3},   // R2 just past window 4
        {24'h810000, 3'd0}    // R5 just past window 3
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [18:0] mk(input logic [11:0] base, input logic [3:0] sz,
                                       input bit pol, input bit ren, input bit en);
        return {base, sz, pol, ren, en};
    endfunction

    // Write one slot; entered and left at posedge + 1.
    task automatic wr(input logic [2:0] sel, input logic [18:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // One bus cycle with timing checks; entered and left at posedge + 1.
    task automatic cyc(input logic [23:0] a, input logic [2:0] ei, input string tag);
        logic [4:0] ecs;
        ecs = ~(5'd1 << ei);
        ale = 1'b1; addr_blk = a[23:12];
        @(posedge clk); #1;
        ale = 1'b0;
        if (early_m) chk(cs_n == ecs, "R7", cs_n, ecs);
        else         chk(cs_n == 5'h1F, "R8", cs_n, 5'h1F);
        addr_blk = ~a[23:12];
        @(negedge clk); #1;
        chk(cs_n == ecs, tag, cs_n, ecs);
        chk(cfg_idx == ei, tag, cfg_idx, ei);
        chk({rdy_pol, rdy_en} == exp_rdy[ei], "R10", {rdy_pol, rdy_en}, exp_rdy[ei]);
        cyc_end = 1'b1;
        @(posedge clk); #1;
        cyc_end = 1'b0;
        if (early_m) chk(cs_n == 5'h1F, "R6", cs_n, 5'h1F);
        else         chk(cs_n == ecs, "R8", cs_n, ecs);
        @(negedge clk); #1;
        chk(cs_n == 5'h1F, "R6", cs_n, 5'h1F);
        chk(cfg_idx == ei, "R9", cfg_idx, ei);
        @(posedge clk); #1;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        exp_rdy[0] = 2'b00; exp_rdy[1] = 2'b00; exp_rdy[2] = 2'b00;
        exp_rdy[3] = 2'b00; exp_rdy[4] = 2'b00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk); #1;
        chk(cs_n == 5'h1F, "R1", cs_n, 5'h1F);
        chk(cfg_idx == 3'd0, "R1", cfg_idx, 0);
        chk({rdy_pol, rdy_en} == 2'b00, "R1", {rdy_pol, rdy_en}, 0);
        @(posedge clk); #1;
        cyc(24'h808ABC, 3'd0, "R1");

        // R12 programming through every slot kind
        wr(3'd0, mk(12'h000, 4'd0, 1'b0, 1'b1, 1'b0)); exp_rdy[0] = 2'b01;
        wr(3'd1, mk(12'h000, 4'd8, 1'b0, 1'b0, 1'b1));
        wr(3'd2, mk(12'h040, 4'd2, 1'b1, 1'b1, 1'b1)); exp_rdy[2] = 2'b11;
        wr(3'd3, mk(12'h805, 4'd4, 1'b0, 1'b0, 1'b1));
        wr(3'd4, mk(12'h808, 4'd0, 1'b1, 1'b0, 1'b1)); exp_rdy[4] = 2'b10;

        for (int m = 0; m < 2; m++) begin
            if (m == 1) begin
                wr(3'd5, 19'd1);    // R12 control slot, early timing
                early_m = 1;
            end
            for (int i = 0; i < 8; i++)
                cyc(VEC[i][26:3], VEC[i][2:0], (VEC[i][2:0] == 3'd0) ? "R5" : "R2");
        end

        // R11: disabled window 4 no longer claims its range
        wr(3'd4, mk(12'h808, 4'd0, 1'b1, 1'b0, 1'b0));
        cyc(24'h808ABC, 3'd3, "R11");
        // R4: window 3 over window 1 across groups
        wr(3'd3, mk(12'h000, 4'd0, 1'b0, 1'b0, 1'b1));
        cyc(24'h000100, 3'd3, "R4");
        cyc(24'h001100, 3'd1, "R2");
        // R4: window 4 over windows 2 and 1, back in delayed timing
        wr(3'd5, 19'd0);
        early_m = 0;
        wr(3'd4, mk(12'h040, 4'd0, 1'b1, 1'b0, 1'b1));
        cyc(24'h040100, 3'd4, "R4");
        cyc(24'h041100, 3'd2, "R3");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule